// File: doc/BRIEF.md
# Interrupt-Return Privilege Check Sequencer

This block carries out the return-from-interrupt step of a segmented protected-mode core. After a `start` pulse it reads the saved instruction pointer, code selector and flags image from the stack through a read port. It then fetches the descriptor of the returning code segment and checks it against the current privilege level. The selector's requested privilege decides the next step. If it equals the current level, the block finishes at once. If it names a less privileged level, the block also pops the saved stack pointer and stack selector and then validates the stack descriptor.

When the sequence ends, the block raises a one-cycle `done`. With it come either a fault class and error code, or the new code selector, instruction pointer, flags, privilege level and, for an outer return, the new stack selector and pointer. For an outer return it also scrubs the four data segment selectors: any selector that the new privilege level may no longer use becomes the null selector. A nested-task return and a return into virtual-8086 mode are not carried out. They are only reported on exit flags.

Descriptor storage sits outside the block. It answers through a request/response port that reports the segment's attributes and limit.

Top module: `iret_priv_seq`

## Requirements
- R1: While reset is held and after it is released, with no `start`, `busy`, `done`, `stk_req` and `dsc_req` are all low.
- R2: At `start` the stack must hold 12 bytes (32-bit operand size) or 6 bytes (16-bit) from `sp_in` up to and including `slim_in`. If it does not, the block ends with fault class 2 (stack) and code 0 and makes no stack read. Fault class encoding: 0 none, 1 general protection, 2 stack, 3 not present.
- R3: The block reads the stack slots at `sp`, `sp+w` and `sp+2w` (w = 4 or 2) as instruction pointer, code selector and flags. An outer return also reads `sp+3w` and `sp+4w` as stack pointer and stack selector. In 16-bit size, the instruction pointer, flags and stack pointer keep only their low 16 bits.
- R4: A null code selector (all bits above bits [1:0] zero) gives class 1 with code 0 and no descriptor request. A descriptor outside the table, a non-code descriptor, an RPL (selector bits [1:0]) below CPL, or a conforming segment whose DPL exceeds the RPL each give class 1 with the selector as code. `dsc_attr` bits: [6] in table, [5] present, [4] code, [3] conforming, [2] writable, [1:0] DPL.
- R5: A code descriptor that passes R4 but is not present gives class 3 with the code selector as code.
- R6: RPL equal to CPL takes the same-level path. It pops nothing more, keeps CPL, and leaves the data selectors unchanged and `outer_ret` low.
- R7: RPL above CPL takes the outer path. This path first needs 8 more bytes (32-bit) or 4 more (16-bit), so 20 or 10 bytes in total from `sp_in`. If they are missing, the result is class 2 with code 0.
- R8: On the outer path, a null stack selector gives class 1 with code 0. A descriptor outside the table, a stack RPL different from the code RPL, a code or non-writable descriptor, or a DPL different from the code RPL each give class 1 with the stack selector. A stack descriptor that is not present then gives class 2 with the stack selector.
- R9: A returned instruction pointer above the code segment limit gives class 1 with code 0. A value equal to the limit is accepted.
- R10: After a good return, `new_cpl` is the RPL of the code selector. On the outer path, each data selector whose check bit is 1 (data or non-conforming code) and whose DPL is below the new CPL is replaced by zero. The others pass unchanged.
- R11: A set nested-task input ends the operation at once with `exit_task`. Flags bit 17 set while CPL is 0 ends it after the flags pop with `exit_v86`. Both exits report class 0. In 16-bit size bit 17 is masked off and never exits.
- R12: At most one of `stk_req` and `dsc_req` is high in a cycle, and `done` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a return operation |
| op32 | input | 1 | 1: 32-bit operand size, 0: 16-bit |
| cpl_in | input | 2 | Current privilege level |
| nt_in | input | 1 | Nested-task flag |
| sp_in | input | 32 | Current stack pointer |
| slim_in | input | 32 | Highest valid stack byte address |
| stk_req | output | 1 | Stack read request |
| stk_addr | output | 32 | Stack read address |
| stk_valid | input | 1 | Stack read data valid |
| stk_rdata | input | 32 | Stack read data |
| dsc_req | output | 1 | Descriptor request |
| dsc_sel | output | 16 | Selector whose descriptor is requested |
| dsc_valid | input | 1 | Descriptor response valid |
| dsc_attr | input | 7 | Descriptor attributes (see R4) |
| dsc_limit | input | 32 | Segment limit |
| dseg_sel_in | input | 64 | Four data selectors, 16 bits each |
| dseg_dpl_in | input | 8 | DPL of each data segment, 2 bits each |
| dseg_chk_in | input | 4 | 1: segment is data or non-conforming code |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_class | output | 2 | Fault class (see R2) |
| fault_code | output | 16 | Error code |
| exit_task | output | 1 | Nested-task return requested |
| exit_v86 | output | 1 | Virtual-8086 return requested |
| outer_ret | output | 1 | Outer-privilege path taken |
| new_cs | output | 16 | Returned code selector |
| new_eip | output | 32 | Returned instruction pointer |
| new_eflags | output | 32 | Returned flags image |
| new_ss | output | 16 | Returned stack selector (outer path) |
| new_esp | output | 32 | Returned stack pointer (outer path) |
| new_cpl | output | 2 | New privilege level |
| dseg_sel_out | output | 64 | Data selectors after scrubbing |

## Verification
The bench probes each stack-room boundary one byte short and exactly met, in both operand sizes and on both paths. A block that is off by one in its room arithmetic therefore faults a legal return or accepts an overflow. Every link in the code and stack descriptor chains is broken on its own, and the resulting class and code are compared. A block that ran the checks in the wrong order, or carried the wrong code, would raise a general-protection fault where a not-present or stack fault belongs, or report the wrong selector.

Other cases cover the mode-dependent behaviour. A 16-bit return feeds in flags with bit 17 set and upper-half garbage, which catches missing masking: a block without it would take the virtual-8086 exit or return a wide pointer. Outer returns to levels 2 and 3 check that only the more privileged data or non-conforming selectors are cleared. Same-level returns check that no selector is cleared.

// File: rtl/iret_pkg.sv
package iret_pkg;
   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_GP   = 2'd1,
      FLT_SS   = 2'd2,
      FLT_NP   = 2'd3
   } flt_e;

   typedef struct packed {
      logic       in_table;
      logic       present;
      logic       is_code;
      logic       conforming;
      logic       writable;
      logic [1:0] dpl;
   } attr_t;

   typedef struct packed {
      flt_e        cls;
      logic [15:0] code;
   } flt_t;
endpackage

// File: rtl/iret_cs_check.sv
module iret_cs_check #(
   parameter int SELW = 16
) (
   input  logic [SELW-1:0] sel,
   input  logic            in_table,
   input  logic            present,
   input  logic            is_code,
   input  logic            conforming,
   input  logic [1:0]      dpl,
   input  logic [1:0]      cpl,
   output iret_pkg::flt_t  flt
);
   logic [1:0] rpl;
   assign rpl = sel[1:0];

   always_comb begin
      flt.cls  = iret_pkg::FLT_NONE;
      flt.code = '0;
      if (!in_table || !is_code || (rpl < cpl) || (conforming && (dpl > rpl))) begin
         flt.cls  = iret_pkg::FLT_GP;
         flt.code = 16'(sel);
      end else if (!present) begin
         flt.cls  = iret_pkg::FLT_NP;
         flt.code = 16'(sel);
      end
   end
endmodule

// File: rtl/iret_ss_check.sv
module iret_ss_check #(
   parameter int SELW = 16
) (
   input  logic [SELW-1:0] sel,
   input  logic            in_table,
   input  logic            present,
   input  logic            is_code,
   input  logic            writable,
   input  logic [1:0]      dpl,
   input  logic [1:0]      code_rpl,
   output iret_pkg::flt_t  flt
);
   always_comb begin
      flt.cls  = iret_pkg::FLT_NONE;
      flt.code = '0;
      if (!in_table || (sel[1:0] != code_rpl) || is_code || !writable || (dpl != code_rpl)) begin
         flt.cls  = iret_pkg::FLT_GP;
         flt.code = 16'(sel);
      end else if (!present) begin
         flt.cls  = iret_pkg::FLT_SS;
         flt.code = 16'(sel);
      end
   end
endmodule

// File: rtl/iret_dseg_scrub.sv
module iret_dseg_scrub #(
   parameter int NSEG = 4,
   parameter int SELW = 16
) (
   input  logic               en,
   input  logic [1:0]         cpl,
   input  logic [NSEG*SELW-1:0] sel_in,
   input  logic [NSEG*2-1:0]  dpl_in,
   input  logic [NSEG-1:0]    chk_in,
   output logic [NSEG*SELW-1:0] sel_out
);
   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic drop;
      assign drop = en && chk_in[g] && (dpl_in[g*2 +: 2] < cpl);
      assign sel_out[g*SELW +: SELW] = drop ? '0 : sel_in[g*SELW +: SELW];
   end
endmodule

// File: rtl/iret_priv_seq.sv
module iret_priv_seq #(
   parameter int DW     = 32,
   parameter int SELW   = 16,
   parameter int NSEG   = 4,
   parameter int VM_BIT = 17
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 op32,
   input  logic [1:0]           cpl_in,
   input  logic                 nt_in,
   input  logic [DW-1:0]        sp_in,
   input  logic [DW-1:0]        slim_in,
   output logic                 stk_req,
   output logic [DW-1:0]        stk_addr,
   input  logic                 stk_valid,
   input  logic [DW-1:0]        stk_rdata,
   output logic                 dsc_req,
   output logic [SELW-1:0]      dsc_sel,
   input  logic                 dsc_valid,
   input  logic [6:0]           dsc_attr,
   input  logic [DW-1:0]        dsc_limit,
   input  logic [NSEG*SELW-1:0] dseg_sel_in,
   input  logic [NSEG*2-1:0]    dseg_dpl_in,
   input  logic [NSEG-1:0]      dseg_chk_in,
   output logic                 busy,
   output logic                 done,
   output logic [1:0]           fault_class,
   output logic [15:0]          fault_code,
   output logic                 exit_task,
   output logic                 exit_v86,
   output logic                 outer_ret,
   output logic [SELW-1:0]      new_cs,
   output logic [DW-1:0]        new_eip,
   output logic [DW-1:0]        new_eflags,
   output logic [SELW-1:0]      new_ss,
   output logic [DW-1:0]        new_esp,
   output logic [1:0]           new_cpl,
   output logic [NSEG*SELW-1:0] dseg_sel_out
);
   import iret_pkg::*;

   localparam int EW  = DW + 1;
   localparam int SW  = NSEG * SELW;
   localparam int NS  = 10;
   localparam int S_IDLE = 0, S_PIP = 1, S_PCS = 2, S_PFL = 3, S_RCS = 4;
   localparam int S_PSP  = 5, S_PSS = 6, S_RSS = 7, S_FIN = 8, S_DONE = 9;

   if (DW < 32) begin : g_bad_dw
      $error("DW must be at least 32");
   end
   if (SELW < 3 || SELW > 16) begin : g_bad_selw
      $error("SELW must lie in 3..16");
   end
   if (VM_BIT >= DW || VM_BIT < 16) begin : g_bad_vm
      $error("VM_BIT must lie in the upper half of a 32-bit flags word");
   end
   if (NSEG < 1) begin : g_bad_nseg
      $error("NSEG must be at least 1");
   end

   function automatic logic [NS-1:0] oh(input int idx);
      return NS'(1) << idx;
   endfunction

   logic [NS-1:0]   st;
   logic            op32_q, nt_unused;
   logic [1:0]      cpl_q, new_cpl_q;
   logic [DW-1:0]   sp_q, slim_q, eip_q, fl_q, esp_q, climit_q;
   logic [SELW-1:0] cs_q, ss_q;
   logic            outer_q, exit_task_q, exit_v86_q;
   flt_e            flt_cls_q;
   logic [15:0]     flt_code_q;
   logic [SW-1:0]   dseg_q, scrub_out;
   logic [NSEG*2-1:0] dpl_q;
   logic [NSEG-1:0] chk_q;

   assign nt_unused = 1'b0;

   // stack room and addressing
   logic [EW-1:0] end3, end5;
   logic          room3_ok, room5_ok;
   logic [DW-1:0] wmask;
   logic [2:0]    pidx;
   logic [DW-1:0] rd_masked;

   assign end3     = {1'b0, sp_in} + EW'(op32 ? 12 : 6) - EW'(1);
   assign room3_ok = end3 <= {1'b0, slim_in};
   assign end5     = {1'b0, sp_q} + EW'(op32_q ? 20 : 10) - EW'(1);
   assign room5_ok = end5 <= {1'b0, slim_q};
   assign wmask    = op32_q ? '1 : DW'(16'hFFFF);
   assign rd_masked = stk_rdata & wmask;

   always_comb begin
      pidx = 3'd0;
      if (st[S_PCS]) pidx = 3'd1;
      if (st[S_PFL]) pidx = 3'd2;
      if (st[S_PSP]) pidx = 3'd3;
      if (st[S_PSS]) pidx = 3'd4;
   end

   logic cs_null, ss_null;
   assign cs_null = (cs_q[SELW-1:2] == '0);
   assign ss_null = (ss_q[SELW-1:2] == '0);

   assign stk_req  = st[S_PIP] | st[S_PCS] | st[S_PFL] | st[S_PSP] | st[S_PSS];
   assign stk_addr = sp_q + (DW'(pidx) << (op32_q ? 2 : 1));
   assign dsc_req  = (st[S_RCS] && !cs_null) || (st[S_RSS] && !ss_null);
   assign dsc_sel  = st[S_RSS] ? ss_q : cs_q;

   attr_t attr;
   assign attr = attr_t'(dsc_attr);

   flt_t cs_flt, ss_flt;

   iret_cs_check #(.SELW(SELW)) u_cs_chk (
      .sel        (cs_q),
      .in_table   (attr.in_table),
      .present    (attr.present),
      .is_code    (attr.is_code),
      .conforming (attr.conforming),
      .dpl        (attr.dpl),
      .cpl        (cpl_q),
      .flt        (cs_flt)
   );

   iret_ss_check #(.SELW(SELW)) u_ss_chk (
      .sel      (ss_q),
      .in_table (attr.in_table),
      .present  (attr.present),
      .is_code  (attr.is_code),
      .writable (attr.writable),
      .dpl      (attr.dpl),
      .code_rpl (cs_q[1:0]),
      .flt      (ss_flt)
   );

   iret_dseg_scrub #(.NSEG(NSEG), .SELW(SELW)) u_scrub (
      .en      (outer_q),
      .cpl     (cs_q[1:0]),
      .sel_in  (dseg_q),
      .dpl_in  (dpl_q),
      .chk_in  (chk_q),
      .sel_out (scrub_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= oh(S_IDLE);
         op32_q      <= 1'b0;
         cpl_q       <= '0;
         new_cpl_q   <= '0;
         sp_q        <= '0;
         slim_q      <= '0;
         eip_q       <= '0;
         fl_q        <= '0;
         esp_q       <= '0;
         climit_q    <= '0;
         cs_q        <= '0;
         ss_q        <= '0;
         outer_q     <= 1'b0;
         exit_task_q <= 1'b0;
         exit_v86_q  <= 1'b0;
         flt_cls_q   <= FLT_NONE;
         flt_code_q  <= '0;
         dseg_q      <= '0;
         dpl_q       <= '0;
         chk_q       <= '0;
      end else begin
         case (1'b1)
            st[S_IDLE]: if (start) begin
               op32_q      <= op32;
               cpl_q       <= cpl_in;
               new_cpl_q   <= cpl_in;
               sp_q        <= sp_in;
               slim_q      <= slim_in;
               dseg_q      <= dseg_sel_in;
               dpl_q       <= dseg_dpl_in;
               chk_q       <= dseg_chk_in;
               outer_q     <= 1'b0;
               exit_task_q <= 1'b0;
               exit_v86_q  <= 1'b0;
               flt_cls_q   <= FLT_NONE;
               flt_code_q  <= '0;
               if (nt_in) begin
                  exit_task_q <= 1'b1;
                  st          <= oh(S_DONE);
               end else if (!room3_ok) begin
                  flt_cls_q <= FLT_SS;
                  st        <= oh(S_DONE);
               end else begin
                  st <= oh(S_PIP);
               end
            end
            st[S_PIP]: if (stk_valid) begin
               eip_q <= rd_masked;
               st    <= oh(S_PCS);
            end
            st[S_PCS]: if (stk_valid) begin
               cs_q <= stk_rdata[SELW-1:0];
               st   <= oh(S_PFL);
            end
            st[S_PFL]: if (stk_valid) begin
               fl_q <= rd_masked;
               if (rd_masked[VM_BIT] && (cpl_q == 2'd0)) begin
                  exit_v86_q <= 1'b1;
                  st         <= oh(S_DONE);
               end else begin
                  st <= oh(S_RCS);
               end
            end
            st[S_RCS]: begin
               if (cs_null) begin
                  flt_cls_q <= FLT_GP;
                  st        <= oh(S_DONE);
               end else if (dsc_valid) begin
                  climit_q <= dsc_limit;
                  if (cs_flt.cls != FLT_NONE) begin
                     flt_cls_q  <= cs_flt.cls;
                     flt_code_q <= cs_flt.code;
                     st         <= oh(S_DONE);
                  end else if (cs_q[1:0] > cpl_q) begin
                     outer_q <= 1'b1;
                     if (!room5_ok) begin
                        flt_cls_q <= FLT_SS;
                        st        <= oh(S_DONE);
                     end else begin
                        st <= oh(S_PSP);
                     end
                  end else begin
                     st <= oh(S_FIN);
                  end
               end
            end
            st[S_PSP]: if (stk_valid) begin
               esp_q <= rd_masked;
               st    <= oh(S_PSS);
            end
            st[S_PSS]: if (stk_valid) begin
               ss_q <= stk_rdata[SELW-1:0];
               st   <= oh(S_RSS);
            end
            st[S_RSS]: begin
               if (ss_null) begin
                  flt_cls_q <= FLT_GP;
                  st        <= oh(S_DONE);
               end else if (dsc_valid) begin
                  if (ss_flt.cls != FLT_NONE) begin
                     flt_cls_q  <= ss_flt.cls;
                     flt_code_q <= ss_flt.code;
                     st         <= oh(S_DONE);
                  end else begin
                     st <= oh(S_FIN);
                  end
               end
            end
            st[S_FIN]: begin
               if (eip_q > climit_q) begin
                  flt_cls_q <= FLT_GP;
               end else begin
                  new_cpl_q <= cs_q[1:0];
                  dseg_q    <= scrub_out;
               end
               st <= oh(S_DONE);
            end
            default: st <= oh(S_IDLE);
         endcase
      end
   end

   assign busy         = !st[S_IDLE] || nt_unused;
   assign done         = st[S_DONE];
   assign fault_class  = flt_cls_q;
   assign fault_code   = flt_code_q;
   assign exit_task    = exit_task_q;
   assign exit_v86     = exit_v86_q;
   assign outer_ret    = outer_q;
   assign new_cs       = cs_q;
   assign new_eip      = eip_q;
   assign new_eflags   = fl_q;
   assign new_ss       = ss_q;
   assign new_esp      = esp_q;
   assign new_cpl      = new_cpl_q;
   assign dseg_sel_out = dseg_q;

   // R12
   st_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot(st));
   // R12
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(stk_req && dsc_req));
   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   // R5
   np_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault_class == 2'd3) |-> (fault_code == 16'(new_cs)));
   // R2
   room_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault_class == 2'd2 && !outer_ret) |-> (fault_code == 16'd0));
   // R11
   exit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (exit_task || exit_v86)) |-> (fault_class == 2'd0 && !(exit_task && exit_v86)));
   // R6
   same_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault_class == 2'd0 && !exit_task && !exit_v86 && !outer_ret) |-> (new_cpl == cpl_q));
endmodule

// File: tb/iret_priv_seq_test.sv
module iret_priv_seq_test;
   typedef struct packed {
      logic [7:0]  rq;
      logic        op32;
      logic [1:0]  cpl;
      logic        nt;
      logic [31:0] slim;
      logic [31:0] eip;
      logic [15:0] cs;
      logic [31:0] fl;
      logic [15:0] ss;
      logic [7:0]  cd;
      logic [7:0]  sd;
      logic [31:0] climit;
      logic [1:0]  ecls;
      logic [15:0] ecode;
      logic [1:0]  eexit;
   } vec_t;

   function automatic vec_t mk(input int rq, input bit op32, input int cpl, input bit nt,
                               input logic [31:0] slim, input logic [31:0] eip,
                               input logic [15:0] cs, input logic [31:0] fl,
                               input logic [15:0] ss, input logic [7:0] cd, input logic [7:0] sd,
                               input logic [31:0] climit, input int ecls,
                               input logic [15:0] ecode, input int eexit);
      vec_t v;
      v.rq = 8'(rq); v.op32 = op32; v.cpl = 2'(cpl); v.nt = nt; v.slim = slim; v.eip = eip;
      v.cs = cs; v.fl = fl; v.ss = ss; v.cd = cd; v.sd = sd; v.climit = climit;
      v.ecls = 2'(ecls); v.ecode = ecode; v.eexit = 2'(eexit);
      return v;
   endfunction

   localparam int NV = 28;
   localparam vec_t V [NV] = '{
      mk(6, 1,0,0,32'hFFFF,32'h2000,16'h0008,32'h0202,16'h0010,8'hE0,8'hCE,32'hFFFF,0,16'h0000,0), // R6
      mk(10,1,0,0,32'hFFFF,32'h2000,16'h001B,32'h0202,16'h0023,8'hE6,8'hCE,32'hFFFF,0,16'h0000,0), // R10
      mk(2, 1,0,0,32'h100A,32'h2000,16'h0008,32'h0202,16'h0010,8'hE0,8'hCE,32'hFFFF,2,16'h0000,0), // R2
      mk(2, 1,0,0,32'h100B,32'h2000,16'h0008,32'h0202,16'h0010,8'hE0,8'hCE,32'hFFFF,0,16'h0000,0), // R2
      mk(4, 1,0,0,32'hFFFF,32'h2000,16'h0003,32'h0202,16'h0010,8'hE0,8'hCE,32'hFFFF,1,16'h0000,0), // R4
      mk(4, 1,0,0,32'hFFFF,32'h2000,16'h0008,32'h0202,16'h0010,8'h66,8'hCE,32'hFFFF,1,16'h0008,0), // R4
      mk(4, 1,0,0,32'hFFFF,32'h2000,16'h0008,32'h0202,16'h0010,8'hC0,8'hCE,32'hFFFF,1,16'h0008,0), // R4
      mk(4, 1,3,0,32'hFFFF,32'h2000,16'h0008,32'h0202,16'h0010,8'hE0,8'hCE,32'hFFFF,1,16'h0008,0), // R4
      mk(4, 1,0,0,32'hFFFF,32'h2000,16'h0009,32'h0202,16'h0010,8'hF4,8'hCE,32'hFFFF,1,16'h0009,0), // R4
      mk(5, 1,0,0,32'hFFFF,32'h2000,16'h0008,32'h0202,16'h0010,8'hA0,8'hCE,32'hFFFF,3,16'h0008,0), // R5
      mk(9, 1,0,0,32'hFFFF,32'h2000,16'h0008,32'h0202,16'h0010,8'hE0,8'hCE,32'h1FFF,1,16'h0000,0), // R9
      mk(9, 1,0,0,32'hFFFF,32'h2000,16'h0008,32'h0202,16'h0010,8'hE0,8'hCE,32'h2000,0,16'h0000,0), // R9
      mk(7, 1,0,0,32'h1012,32'h2000,16'h001B,32'h0202,16'h0023,8'hE6,8'hCE,32'hFFFF,2,16'h0000,0), // R7
      mk(7, 1,0,0,32'h1013,32'h2000,16'h001B,32'h0202,16'h0023,8'hE6,8'hCE,32'hFFFF,0,16'h0000,0), // R7
      mk(8, 1,0,0,32'hFFFF,32'h2000,16'h001B,32'h0202,16'h0000,8'hE6,8'hCE,32'hFFFF,1,16'h0000,0), // R8
      mk(8, 1,0,0,32'hFFFF,32'h2000,16'h001B,32'h0202,16'h0022,8'hE6,8'hCE,32'hFFFF,1,16'h0022,0), // R8
      mk(8, 1,0,0,32'hFFFF,32'h2000,16'h001B,32'h0202,16'h0023,8'hE6,8'hC6,32'hFFFF,1,16'h0023,0), // R8
      mk(8, 1,0,0,32'hFFFF,32'h2000,16'h001B,32'h0202,16'h0023,8'hE6,8'hCC,32'hFFFF,1,16'h0023,0), // R8
      mk(8, 1,0,0,32'hFFFF,32'h2000,16'h001B,32'h0202,16'h0023,8'hE6,8'h8E,32'hFFFF,2,16'h0023,0), // R8
      mk(8, 1,0,0,32'hFFFF,32'h2000,16'h001B,32'h0202,16'h0023,8'hE6,8'h4E,32'hFFFF,1,16'h0023,0), // R8
      mk(11,1,0,1,32'hFFFF,32'h2000,16'h0008,32'h0202,16'h0010,8'hE0,8'hCE,32'hFFFF,0,16'h0000,1), // R11
      mk(11,1,0,0,32'hFFFF,32'h2000,16'h0008,32'h20202,16'h0010,8'hE0,8'hCE,32'hFFFF,0,16'h0000,2), // R11
      mk(11,1,3,0,32'hFFFF,32'h2000,16'h001B,32'h20202,16'h0010,8'hE6,8'hCE,32'hFFFF,0,16'h0000,0), // R11
      mk(3, 0,0,0,32'h1009,32'hABCD2000,16'h001B,32'h30202,16'h0023,8'hE6,8'hCE,32'hFFFF,0,16'h0000,0), // R3
      mk(7, 0,0,0,32'h1008,32'hABCD2000,16'h001B,32'h30202,16'h0023,8'hE6,8'hCE,32'hFFFF,2,16'h0000,0), // R7
      mk(3, 0,0,0,32'h1005,32'h12345678,16'h0008,32'h0202,16'h0010,8'hE0,8'hCE,32'hFFFF,0,16'h0000,0), // R3
      mk(10,1,0,0,32'hFFFF,32'h2000,16'h0012,32'h0202,16'h001A,8'hE4,8'hCC,32'hFFFF,0,16'h0000,0), // R10
      mk(8, 1,0,0,32'hFFFF,32'h2000,16'h001B,32'h0202,16'h0023,8'hE6,8'hEE,32'hFFFF,1,16'h0023,0)  // R8
   };

   localparam logic [31:0] SP0  = 32'h1000;
   localparam logic [31:0] ESPV = 32'h8000_7FF0;
   localparam logic [63:0] DSEL = {16'h0048, 16'h0030, 16'h002B, 16'h0010};
   localparam logic [7:0]  DDPL = {2'd2, 2'd0, 2'd3, 2'd0};
   localparam logic [3:0]  DCHK = 4'b1011;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op32 = 1'b1;
   logic [1:0]  cpl_in = '0;
   logic        nt_in = 1'b0;
   logic [31:0] sp_in = SP0;
   logic [31:0] slim_in = '0;
   logic        stk_req, dsc_req, stk_valid, dsc_valid;
   logic [31:0] stk_addr, stk_rdata, dsc_limit;
   logic [15:0] dsc_sel;
   logic [6:0]  dsc_attr;
   logic        busy, done, exit_task, exit_v86, outer_ret;
   logic [1:0]  fault_class, new_cpl;
   logic [15:0] fault_code, new_cs, new_ss;
   logic [31:0] new_eip, new_eflags, new_esp;
   logic [63:0] dseg_sel_out;
   vec_t        cur = V[0];

   int checks = 0;
   int errors = 0;
   int both_cnt = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   iret_priv_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op32(op32), .cpl_in(cpl_in), .nt_in(nt_in),
      .sp_in(sp_in), .slim_in(slim_in),
      .stk_req(stk_req), .stk_addr(stk_addr), .stk_valid(stk_valid), .stk_rdata(stk_rdata),
      .dsc_req(dsc_req), .dsc_sel(dsc_sel), .dsc_valid(dsc_valid), .dsc_attr(dsc_attr),
      .dsc_limit(dsc_limit),
      .dseg_sel_in(DSEL), .dseg_dpl_in(DDPL), .dseg_chk_in(DCHK),
      .busy(busy), .done(done), .fault_class(fault_class), .fault_code(fault_code),
      .exit_task(exit_task), .exit_v86(exit_v86), .outer_ret(outer_ret),
      .new_cs(new_cs), .new_eip(new_eip), .new_eflags(new_eflags), .new_ss(new_ss),
      .new_esp(new_esp), .new_cpl(new_cpl), .dseg_sel_out(dseg_sel_out)
   );

   // stack model: slots counted from SP0 in units of the operand size
   always_comb begin
      logic [31:0] slot;
      slot      = (stk_addr - SP0) >> (cur.op32 ? 2 : 1);
      stk_valid = stk_req;
      case (slot)
         32'd0:   stk_rdata = cur.eip;
         32'd1:   stk_rdata = {16'hBEEF, cur.cs};
         32'd2:   stk_rdata = cur.fl;
         32'd3:   stk_rdata = ESPV;
         32'd4:   stk_rdata = {16'h0000, cur.ss};
         default: stk_rdata = 32'hDEAD_DEAD;
      endcase
   end

   // descriptor model
   always_comb begin
      dsc_valid = dsc_req;
      if (dsc_sel == cur.cs) begin
         dsc_attr  = cur.cd[7:1];
         dsc_limit = cur.climit;
      end else begin
         dsc_attr  = cur.sd[7:1];
         dsc_limit = 32'hFFFF_FFFF;
      end
   end

   always @(negedge clk) if (stk_req && dsc_req) both_cnt++;

   task automatic chk(input int rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s act=%h exp=%h", rq, what, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      bit          ok;
      bit          outer;
      logic [31:0] m;
      logic [63:0] exp_dseg;
      int          rq;
      rq = int'(v.rq);
      @(negedge clk);
      cur     = v;
      op32    = v.op32;
      cpl_in  = v.cpl;
      nt_in   = v.nt;
      slim_in = v.slim;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ok = 1'b0;
      for (int k = 0; k < 60; k++) begin
         if (done) begin ok = 1'b1; break; end
         @(negedge clk);
      end
      chk(rq, "done seen", 64'(ok), 64'd1);
      if (!ok) return;
      chk(rq, "fault class", 64'(fault_class), 64'(v.ecls));
      chk(rq, "fault code", 64'(fault_code), 64'(v.ecode));
      chk(rq, "exit flags", 64'({exit_v86, exit_task}), 64'(v.eexit));
      if (v.ecls == 2'd0 && v.eexit == 2'd0) begin
         m     = v.op32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
         outer = v.cs[1:0] > v.cpl;
         chk(rq, "new eip", 64'(new_eip), 64'(v.eip & m));
         chk(rq, "new cs", 64'(new_cs), 64'(v.cs));
         chk(rq, "new flags", 64'(new_eflags), 64'(v.fl & m));
         chk(rq, "new cpl", 64'(new_cpl), 64'(v.cs[1:0]));
         chk(rq, "outer path", 64'(outer_ret), 64'(outer));
         exp_dseg = DSEL;
         if (outer) begin
            chk(rq, "new esp", 64'(new_esp), 64'(ESPV & m));
            chk(rq, "new ss", 64'(new_ss), 64'(v.ss));
            for (int s = 0; s < 4; s++)
               if (DCHK[s] && (DDPL[s*2 +: 2] < v.cs[1:0])) exp_dseg[s*16 +: 16] = 16'h0;
         end
         chk(rq, "data selectors", dseg_sel_out, exp_dseg);
      end
      @(negedge clk);
      chk(12, "done width", 64'(done), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(1, "reset busy", 64'(busy), 64'd0);
      chk(1, "reset done", 64'(done), 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 after reset, no start
      chk(1, "idle busy", 64'(busy), 64'd0);
      chk(1, "idle requests", 64'({stk_req, dsc_req}), 64'd0);
      chk(1, "idle done", 64'(done), 64'd0);

      for (int i = 0; i < NV; i++) run_vec(V[i]);

      // R12 one request per cycle across every run
      chk(12, "simultaneous requests", 64'(both_cnt), 64'd0);

      // R2 no stack read when room is short: watch requests for a short run
      begin
         int reads;
         vec_t v;
         v = V[2];
         reads = 0;
         @(negedge clk);
         cur = v; op32 = v.op32; cpl_in = v.cpl; nt_in = v.nt; slim_in = v.slim;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         for (int k = 0; k < 5; k++) begin
            if (stk_req) reads++;
            @(negedge clk);
         end
         chk(2, "stack reads on room fault", 64'(reads), 64'd0);
      end

      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule